// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the register-access side of a high-precision event timer. It has a 64-bit main counter and a set of comparator channels, three by default. A host reaches it through a 1 KB address window. Each access carries a byte address and a length of 1, 2, 4 or 8 bytes.

Reads return the selected bytes of a 64-bit register, right-aligned, on `rd_data`. `rd_valid` is high in the cycle after the request. A write narrower than 8 bytes is merged into the addressed register: only its byte lanes change. The block keeps the capability, global configuration, status, main counter and per-channel configuration, comparator and route registers.

The comparator match and interrupt logic of each channel lives outside this block. That logic is told when to start, stop or restart a channel through one-cycle strobes. The strobes follow from changes of the global and per-channel enable bits.

The main counter is governed by a two-state machine:
- States are CNT_HALTED and CNT_RUNNING.
- The transition "enable rise" moves CNT_HALTED to CNT_RUNNING when the global enable bit goes from 0 to 1.
- The transition "enable fall" moves CNT_RUNNING to CNT_HALTED when that bit goes from 1 to 0.
- In CNT_RUNNING the counter adds one on each cycle that `tick_en` is high. In CNT_HALTED it holds.

Top module: `evt_timer_regs`

## Requirements
- R1: After reset, the main counter, the global configuration, every channel configuration and all strobes are zero. No strobe is raised without a write.
- R2: The capability register at offset 0x000 reads {tick period in femtoseconds (default 0x00F42400), 32'h8086A201}, with the period in the upper half. Writes to it have no effect.
- R3: An access whose length is not 1, 2, 4 or 8, or whose address is not a multiple of its length, is rejected. A rejected read returns all ones. A rejected write changes nothing.
- R4: A read returns the addressed 64-bit register shifted right by 8·(addr mod 8) and masked to the access width. `rd_valid` and `rd_data` appear one clock after the request.
- R5: A write narrower than 8 bytes replaces only the byte lanes it covers. The other bytes of the register keep their values.
- R6: In the global configuration at 0x010, only bits 1:0 are writable. Bit 0 is the global enable and bit 1 selects legacy routing. All other bits read zero.
- R7: In a channel configuration register at 0x100+0x20·n, only the bits of mask 0x3F4E are writable. All other bits read zero. Bit 2 is the channel enable, bit 3 is periodic mode, bit 6 is set-accumulator and bit 8 is 32-bit mode.
- R8: The main counter at 0x0F0 adds one per `tick_en` cycle while in CNT_RUNNING. It is frozen in CNT_HALTED. A write to it loads the merged value.
- R9: When global enable rises, every channel with bit 2 set gets a start strobe. When it falls, each such channel gets a stop strobe. Strobes are registered and appear one clock after the write.
- R10: A write to the main counter while it runs gives every enabled channel a restart strobe. While it is halted, such a write gives no strobe.
- R11: A channel configuration write while global enable is set produces strobes as follows. If the new value has the enable bit set and changes periodic mode, or sets 32-bit mode, the channel gets a restart. Otherwise, if the enable bit goes 0 to 1 the channel gets a start, and if it goes 1 to 0 the channel gets a stop. While global enable is clear, such a write gives no strobe.
- R12: A comparator write at 0x108+0x20·n clears configuration bit 6. In 32-bit mode it stores the low 32 bits and zeroes the upper half. If the channel and global enables are both set, the write gives that channel a restart strobe.
- R13: Offsets that are not defined read as 0. Writes to them have no effect. This covers 0x008, the fourth slot 0x118+0x20·n of a channel, and channels beyond the configured count.
- R14: The status register at 0x020 is plain storage. One writable bit exists per channel, in bits [n-1:0]. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler pulse that advances the running counter |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 10 | Byte address within the window |
| acc_len | input | 4 | Access length in bytes |
| acc_wdata | input | 64 | Write data, right-aligned |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data |
| tmr_start | output | NUM_TMR | Per-channel start strobe |
| tmr_stop | output | NUM_TMR | Per-channel stop strobe |
| tmr_restart | output | NUM_TMR | Per-channel restart strobe |

## Verification
The byte-lane paths are tried with full-width, narrow and misaligned accesses to one known 64-bit pattern. This tells correct shifting and lane selection apart from an off-by-one-lane fault, and acceptance apart from rejection.

Strobe generation is driven through each kind of transition in turn: global enable rise and fall, counter writes while halted and while running, and channel configuration writes. The configuration writes cover enabling, disabling, a periodic-mode toggle and setting 32-bit mode. This separates start, stop and restart for the right channel subset.

Counter ticks are applied both in CNT_HALTED and in CNT_RUNNING to show freezing against counting. Writes to read-only and undefined offsets are each followed by a read that would expose a change.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;
    typedef enum logic [0:0] {
        CNT_HALTED  = 1'b0,
        CNT_RUNNING = 1'b1
    } cnt_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CAP,
        SEL_GCFG,
        SEL_STAT,
        SEL_CNT,
        SEL_TCFG,
        SEL_TCMP,
        SEL_TROUTE
    } reg_sel_t;

    localparam logic [9:0] OFS_CAP  = 10'h000;
    localparam logic [9:0] OFS_GCFG = 10'h010;
    localparam logic [9:0] OFS_STAT = 10'h020;
    localparam logic [9:0] OFS_CNT  = 10'h0F0;

    localparam logic [63:0] TCFG_WMASK = 64'h0000_0000_0000_3F4E;
    localparam int TCFG_EN     = 2;
    localparam int TCFG_PER    = 3;
    localparam int TCFG_SETVAL = 6;
    localparam int TCFG_W32    = 8;
    localparam int GCFG_EN     = 0;

    localparam logic [31:0] CAP_LOW = 32'h8086_A201;
endpackage

// File: rtl/evt_lane_unit.sv
`timescale 1ns/1ps
// Length check, byte-lane merge for writes and lane extraction for reads.
module evt_lane_unit (
    input  logic [2:0]  byte_ofs,
    input  logic [3:0]  len,
    input  logic [63:0] wdata,
    input  logic [63:0] old_val,
    output logic        acc_ok,
    output logic [63:0] merged,
    output logic [63:0] rd_lane
);
    logic [63:0] lane;
    logic [5:0]  shift;

    always_comb begin
        unique case (len)
            4'd1:    acc_ok = 1'b1;
            4'd2:    acc_ok = ~byte_ofs[0];
            4'd4:    acc_ok = (byte_ofs[1:0] == 2'b00);
            4'd8:    acc_ok = (byte_ofs == 3'b000);
            default: acc_ok = 1'b0;
        endcase
    end

    always_comb begin
        for (int k = 0; k < 8; k++) begin
            lane[8*k +: 8] = ((k >= int'(byte_ofs)) && (k < int'(byte_ofs) + int'(len)))
                             ? 8'hFF : 8'h00;
        end
    end

    assign shift   = {byte_ofs, 3'b000};
    assign merged  = (old_val & ~lane) | ((wdata << shift) & lane);
    assign rd_lane = (old_val & lane) >> shift;
endmodule

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
// Main counter with halted/running state machine.
module evt_main_counter
    import evt_pkg::*;
#(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          g_rise,
    input  logic          g_fall,
    input  logic          tick_en,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] count,
    output logic          running
);
    cnt_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CNT_HALTED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALTED:  if (g_rise) state_d = CNT_RUNNING;
            CNT_RUNNING: if (g_fall) state_d = CNT_HALTED;
            default:     state_d = CNT_HALTED;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (wr)
            cnt_d = wdata;
        else if (state_q == CNT_RUNNING && tick_en)
            cnt_d = cnt_q + 1'b1;
    end

    assign count   = cnt_q;
    assign running = (state_q == CNT_RUNNING);
endmodule

// File: rtl/evt_timer_chan.sv
`timescale 1ns/1ps
// One comparator channel's registers plus its start/stop/restart strobes.
module evt_timer_chan
    import evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_cfg,
    input  logic        wr_cmp,
    input  logic        wr_route,
    input  logic [63:0] wval,
    input  logic        g_en,
    input  logic        g_rise,
    input  logic        g_fall,
    input  logic        cnt_wr_live,
    output logic [63:0] cfg_q,
    output logic [63:0] cmp_q,
    output logic [63:0] route_q,
    output logic        start_o,
    output logic        stop_o,
    output logic        restart_o
);
    logic [63:0] cfg_new;
    logic        en_old, en_new;
    logic        cfg_restart, cfg_start, cfg_stop;

    assign cfg_new = (cfg_q & ~TCFG_WMASK) | (wval & TCFG_WMASK);
    assign en_old  = cfg_q[TCFG_EN];
    assign en_new  = cfg_new[TCFG_EN];

    assign cfg_restart = wr_cfg && g_en && en_new &&
                         ((cfg_new[TCFG_PER] != cfg_q[TCFG_PER]) ||
                          (cfg_new[TCFG_W32] && !cfg_q[TCFG_W32]));
    assign cfg_start   = wr_cfg && g_en && en_new && !en_old && !cfg_restart;
    assign cfg_stop    = wr_cfg && g_en && !en_new && en_old;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            cmp_q     <= '0;
            route_q   <= '0;
            start_o   <= 1'b0;
            stop_o    <= 1'b0;
            restart_o <= 1'b0;
        end else begin
            if (wr_cfg)
                cfg_q <= cfg_new;
            else if (wr_cmp)
                cfg_q[TCFG_SETVAL] <= 1'b0;
            if (wr_cmp)
                cmp_q <= cfg_q[TCFG_W32] ? {32'h0, wval[31:0]} : wval;
            if (wr_route)
                route_q <= wval;
            start_o   <= cfg_start || (g_rise && en_old);
            stop_o    <= cfg_stop  || (g_fall && en_old);
            restart_o <= cfg_restart || (wr_cmp && g_en && en_old) ||
                         (cnt_wr_live && en_old);
        end
    end
endmodule

// File: rtl/evt_timer_regs.sv
`timescale 1ns/1ps
// Register front end of the event timer: decode, merge, global registers.
module evt_timer_regs
    import evt_pkg::*;
#(
    parameter int          NUM_TMR = 3,
    parameter logic [31:0] TICK_FS = 32'h00F4_2400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_en,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [9:0]         acc_addr,
    input  logic [3:0]         acc_len,
    input  logic [63:0]        acc_wdata,
    output logic               rd_valid,
    output logic [63:0]        rd_data,
    output logic [NUM_TMR-1:0] tmr_start,
    output logic [NUM_TMR-1:0] tmr_stop,
    output logic [NUM_TMR-1:0] tmr_restart
);
    localparam logic [63:0] CAP_VAL = {TICK_FS, CAP_LOW};

    reg_sel_t    sel;
    logic [9:0]  word;
    logic [2:0]  ch_idx;
    logic        ch_in_rng;
    logic [63:0] old_val, merged, rd_lane;
    logic        acc_ok, wr_go;

    logic [1:0]         gcfg_q;
    logic [NUM_TMR-1:0] stat_q;
    logic               g_rise, g_fall, cnt_wr, cnt_wr_live, cnt_running;
    logic [63:0]        cnt_val;

    logic [63:0] cfg_a   [NUM_TMR];
    logic [63:0] cmp_a   [NUM_TMR];
    logic [63:0] route_a [NUM_TMR];

    assign word      = {acc_addr[9:3], 3'b000};
    assign ch_idx    = acc_addr[7:5];
    assign ch_in_rng = (int'(ch_idx) < NUM_TMR);

    always_comb begin
        sel = SEL_NONE;
        if (word == OFS_CAP)       sel = SEL_CAP;
        else if (word == OFS_GCFG) sel = SEL_GCFG;
        else if (word == OFS_STAT) sel = SEL_STAT;
        else if (word == OFS_CNT)  sel = SEL_CNT;
        else if (acc_addr[9:8] == 2'b01 && ch_in_rng) begin
            unique case (acc_addr[4:3])
                2'd0:    sel = SEL_TCFG;
                2'd1:    sel = SEL_TCMP;
                2'd2:    sel = SEL_TROUTE;
                default: sel = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        old_val = '0;
        unique case (sel)
            SEL_CAP:  old_val = CAP_VAL;
            SEL_GCFG: old_val = {62'h0, gcfg_q};
            SEL_STAT: old_val = {{(64-NUM_TMR){1'b0}}, stat_q};
            SEL_CNT:  old_val = cnt_val;
            SEL_TCFG: for (int i = 0; i < NUM_TMR; i++) if (ch_idx == 3'(i)) old_val = cfg_a[i];
            SEL_TCMP: for (int i = 0; i < NUM_TMR; i++) if (ch_idx == 3'(i)) old_val = cmp_a[i];
            SEL_TROUTE: for (int i = 0; i < NUM_TMR; i++) if (ch_idx == 3'(i)) old_val = route_a[i];
            default:  old_val = '0;
        endcase
    end

    evt_lane_unit u_lane (
        .byte_ofs (acc_addr[2:0]),
        .len      (acc_len),
        .wdata    (acc_wdata),
        .old_val  (old_val),
        .acc_ok   (acc_ok),
        .merged   (merged),
        .rd_lane  (rd_lane)
    );

    assign wr_go       = acc_valid && acc_write && acc_ok;
    assign g_rise      = wr_go && (sel == SEL_GCFG) && !gcfg_q[GCFG_EN] && merged[GCFG_EN];
    assign g_fall      = wr_go && (sel == SEL_GCFG) && gcfg_q[GCFG_EN] && !merged[GCFG_EN];
    assign cnt_wr      = wr_go && (sel == SEL_CNT);
    assign cnt_wr_live = cnt_wr && cnt_running;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcfg_q   <= '0;
            stat_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (wr_go && sel == SEL_GCFG) gcfg_q <= merged[1:0];
            if (wr_go && sel == SEL_STAT) stat_q <= merged[NUM_TMR-1:0];
            rd_valid <= acc_valid && !acc_write;
            if (acc_valid && !acc_write)
                rd_data <= acc_ok ? rd_lane : {64{1'b1}};
        end
    end

    evt_main_counter #(.CW(64)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .g_rise  (g_rise),
        .g_fall  (g_fall),
        .tick_en (tick_en),
        .wr      (cnt_wr),
        .wdata   (merged),
        .count   (cnt_val),
        .running (cnt_running)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chan
        evt_timer_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_cfg      (wr_go && sel == SEL_TCFG   && ch_idx == 3'(g)),
            .wr_cmp      (wr_go && sel == SEL_TCMP   && ch_idx == 3'(g)),
            .wr_route    (wr_go && sel == SEL_TROUTE && ch_idx == 3'(g)),
            .wval        (merged),
            .g_en        (gcfg_q[GCFG_EN]),
            .g_rise      (g_rise),
            .g_fall      (g_fall),
            .cnt_wr_live (cnt_wr_live),
            .cfg_q       (cfg_a[g]),
            .cmp_q       (cmp_a[g]),
            .route_q     (route_a[g]),
            .start_o     (tmr_start[g]),
            .stop_o      (tmr_stop[g]),
            .restart_o   (tmr_restart[g])
        );
    end
endmodule

// File: rtl/evt_timer_regs_chk.sv
`timescale 1ns/1ps
// Property checker bound to the register front end.
module evt_timer_regs_chk #(
    parameter int NUM_TMR = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               acc_ok,
    input logic               rd_valid,
    input logic [63:0]        rd_data,
    input logic [NUM_TMR-1:0] tmr_start,
    input logic [NUM_TMR-1:0] tmr_stop,
    input logic [NUM_TMR-1:0] tmr_restart,
    input logic               running,
    input logic               cnt_wr,
    input logic [63:0]        count
);
    // R3: rejected read answers with all ones
    a_r3_reject_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !acc_ok) |=> (rd_valid && rd_data == {64{1'b1}}));

    // R4: a response only follows a read request
    a_r4_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write));

    // R8: halted counter holds unless written
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(count));

    // R8: running counter moves by at most one per cycle
    a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cnt_wr) |=> (count == $past(count) || count == $past(count) + 64'd1));

    // R9: start and stop never coincide on a channel
    a_r9_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_start & tmr_stop) == '0);

    // R1: strobes only follow an accepted write
    a_r1_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|{tmr_start, tmr_stop, tmr_restart}) |-> $past(acc_valid && acc_write && acc_ok));
endmodule

bind evt_timer_regs evt_timer_regs_chk #(.NUM_TMR(NUM_TMR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_write   (acc_write),
    .acc_ok      (acc_ok),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .tmr_start   (tmr_start),
    .tmr_stop    (tmr_stop),
    .tmr_restart (tmr_restart),
    .running     (cnt_running),
    .cnt_wr      (cnt_wr),
    .count       (cnt_val)
);

// File: tb/evt_timer_regs_bench.sv
`timescale 1ns/1ps
module evt_timer_regs_bench;
    localparam logic [63:0] ONES = {64{1'b1}};
    localparam logic [63:0] CAP  = {32'h00F4_2400, 32'h8086_A201};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [9:0]  acc_addr = '0;
    logic [3:0]  acc_len = 4'd8;
    logic [63:0] acc_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [2:0]  tmr_start, tmr_stop, tmr_restart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [63:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    evt_timer_regs u_evt_timer_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .acc_valid   (acc_valid),
        .acc_write   (acc_write),
        .acc_addr    (acc_addr),
        .acc_len     (acc_len),
        .acc_wdata   (acc_wdata),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .tmr_start   (tmr_start),
        .tmr_stop    (tmr_stop),
        .tmr_restart (tmr_restart)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R4 unexpected response act=%h exp=none", rd_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, rd_data, e.val);
            end
        end
    end

    task automatic rd(input logic [9:0] a, input logic [3:0] l, input logic [63:0] exp, input string tag);
        exp_q.push_back('{exp, tag});
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_len = l;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [3:0] l, input logic [63:0] d,
                      input logic [2:0] st, input logic [2:0] sp, input logic [2:0] rs,
                      input string tag);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_len = l; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        check(tag, {55'h0, tmr_start, tmr_stop, tmr_restart}, {55'h0, st, sp, rs});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 strobes at reset", {61'h0, tmr_start | tmr_stop | tmr_restart}, 64'h0);
        rd(10'h010, 4'd8, 64'h0, "R1 gcfg reset");
        rd(10'h0F0, 4'd8, 64'h0, "R1 counter reset");
        rd(10'h100, 4'd8, 64'h0, "R1 tcfg0 reset");

        // R2 capability
        rd(10'h000, 4'd8, CAP, "R2 capability");
        rd(10'h004, 4'd4, 64'h00F4_2400, "R2 period half");
        wr(10'h000, 4'd8, 64'h0, 3'b0, 3'b0, 3'b0, "R2 cap write strobes");
        rd(10'h000, 4'd8, CAP, "R2 cap unchanged");

        // R3 rejection
        rd(10'h002, 4'd4, ONES, "R3 misaligned read");
        rd(10'h000, 4'd3, ONES, "R3 length 3 read");
        rd(10'h000, 4'd9, ONES, "R3 length 9 read");
        wr(10'h110, 4'd8, 64'h1122_3344_5566_7788, 3'b0, 3'b0, 3'b0, "R5 route0 full write");
        wr(10'h111, 4'd2, 64'hFFFF, 3'b0, 3'b0, 3'b0, "R3 misaligned write strobes");
        rd(10'h110, 4'd8, 64'h1122_3344_5566_7788, "R3 misaligned write dropped");

        // R4 narrow reads
        rd(10'h113, 4'd1, 64'h55, "R4 byte read");
        rd(10'h114, 4'd2, 64'h3344, "R4 half read");
        rd(10'h114, 4'd4, 64'h1122_3344, "R4 word read");

        // R5 narrow writes
        wr(10'h112, 4'd2, 64'hABCD, 3'b0, 3'b0, 3'b0, "R5 half write strobes");
        rd(10'h110, 4'd8, 64'h1122_3344_ABCD_7788, "R5 half merge");
        wr(10'h117, 4'd1, 64'h99, 3'b0, 3'b0, 3'b0, "R5 byte write strobes");
        rd(10'h110, 4'd8, 64'h9922_3344_ABCD_7788, "R5 byte merge");

        // R6 global config mask
        wr(10'h010, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE, 3'b0, 3'b0, 3'b0, "R6 gcfg write");
        rd(10'h010, 4'd8, 64'h2, "R6 gcfg mask");
        wr(10'h010, 4'd8, 64'h0, 3'b0, 3'b0, 3'b0, "R6 gcfg clear");

        // R7 channel config mask, R11 no strobe while globally disabled
        wr(10'h100, 4'd8, ONES, 3'b0, 3'b0, 3'b0, "R11 tcfg write while disabled");
        rd(10'h100, 4'd8, 64'h3F4E, "R7 tcfg mask");
        wr(10'h100, 4'd8, 64'h0, 3'b0, 3'b0, 3'b0, "R7 tcfg clear");

        // R13 undefined offsets
        rd(10'h008, 4'd8, 64'h0, "R13 read 0x008");
        rd(10'h160, 4'd8, 64'h0, "R13 read channel 3");
        wr(10'h118, 4'd8, ONES, 3'b0, 3'b0, 3'b0, "R13 write slot 3");
        rd(10'h118, 4'd8, 64'h0, "R13 slot 3 reads zero");
        wr(10'h160, 4'd8, ONES, 3'b0, 3'b0, 3'b0, "R13 write channel 3");
        rd(10'h100, 4'd8, 64'h0, "R13 tcfg0 untouched");

        // R14 status storage
        wr(10'h020, 4'd8, ONES, 3'b0, 3'b0, 3'b0, "R14 status write");
        rd(10'h020, 4'd8, 64'h7, "R14 status bits");
        rd(10'h020, 4'd1, 64'h7, "R14 status byte");

        // halted set-up, R10 halted write, R8 frozen
        wr(10'h100, 4'd8, 64'h4, 3'b0, 3'b0, 3'b0, "R11 enable t0 while disabled");
        wr(10'h140, 4'd8, 64'hC, 3'b0, 3'b0, 3'b0, "R11 enable t2 while disabled");
        wr(10'h0F0, 4'd8, 64'd100, 3'b0, 3'b0, 3'b0, "R10 halted counter write");
        ticks(3);
        rd(10'h0F0, 4'd8, 64'd100, "R8 halted counter frozen");

        // R9 enable rise
        wr(10'h010, 4'd8, 64'h1, 3'b101, 3'b0, 3'b0, "R9 enable rise start");
        rd(10'h010, 4'd8, 64'h1, "R6 gcfg enabled");
        ticks(5);
        rd(10'h0F0, 4'd8, 64'd105, "R8 running counts ticks");
        rd(10'h0F0, 4'd1, 64'h69, "R8 counter byte read");

        // R10 running write
        wr(10'h0F0, 4'd8, 64'd200, 3'b0, 3'b0, 3'b101, "R10 running write restart");
        rd(10'h0F0, 4'd8, 64'd200, "R10 counter loaded");

        // R11 channel transitions
        wr(10'h120, 4'd8, 64'h4, 3'b010, 3'b0, 3'b0, "R11 t1 enable start");
        wr(10'h140, 4'd8, 64'h4, 3'b0, 3'b0, 3'b100, "R11 t2 mode toggle restart");
        wr(10'h100, 4'd8, 64'h104, 3'b0, 3'b0, 3'b001, "R11 t0 32bit restart");
        wr(10'h120, 4'd8, 64'h0, 3'b0, 3'b010, 3'b0, "R11 t1 disable stop");

        // R12 comparator writes
        wr(10'h108, 4'd8, 64'hFFFF_FFFF_1234_5678, 3'b0, 3'b0, 3'b001, "R12 t0 cmp restart");
        rd(10'h108, 4'd8, 64'h1234_5678, "R12 32bit truncation");
        wr(10'h128, 4'd4, 64'h77, 3'b0, 3'b0, 3'b0, "R12 disabled channel no restart");
        wr(10'h140, 4'd8, 64'h44, 3'b0, 3'b0, 3'b0, "R12 setval write");
        rd(10'h140, 4'd8, 64'h44, "R12 setval stored");
        wr(10'h148, 4'd8, 64'h500, 3'b0, 3'b0, 3'b100, "R12 t2 cmp restart");
        rd(10'h140, 4'd8, 64'h4, "R12 setval cleared");
        rd(10'h148, 4'd8, 64'h500, "R12 t2 cmp value");

        // R9 enable fall, R8 frozen
        wr(10'h010, 4'd8, 64'h0, 3'b0, 3'b101, 3'b0, "R9 enable fall stop");
        ticks(3);
        rd(10'h0F0, 4'd8, 64'd200, "R8 frozen after halt");

        @(negedge clk);
        @(negedge clk);
        check("R4 all responses seen", 64'(exp_q.size()), 64'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule